// File: doc/BRIEF.md
# Cross-Domain Timer Register Write Bridge

This block lets logic running on a fast bus clock load three registers of a small timer that runs from a slow, unrelated clock such as a 32.768 kHz crystal. The three registers are the count, the compare threshold and the control word. A bus write first lands in a holding register that belongs to that target alone. A toggle request then carries it into the timer domain, where it is committed to the live register. A toggle acknowledge returns through a two-flop synchronizer and clears that register's busy bit on the bus side.

The timer itself is an 8-bit up-counter with an equality compare. It can optionally clear to zero on a compare hit. Compare hits are carried back to the bus domain as a sticky flag, and a clear strobe resets that flag. While a count or compare commit is pending in the timer domain, compare detection is blocked. This stops a half-updated register pair from raising a false hit. For correct operation the bus clock must be more than four times faster than the timer clock. One active-high reset, held for several timer clock periods, clears both domains.

Top module: `tmr_xdom_wr_bridge`

## Requirements
- R1: After reset, all busy bits, `wr_err`, `match_flag`, `t_count`, `t_compare` and `t_control` read zero.
- R2: A write with `wr_en` high selects a target through `wr_sel` (0 = count, 1 = compare, 2 = control). If that target is idle, its busy bit (same index in `busy`) is high from the next bus clock.
- R3: The written value appears on the live timer register at the second rising `tclk` edge after the write. After the first of those edges, the old value is still shown.
- R4: The busy bit falls within four bus clock cycles after the committing `tclk` edge.
- R5: A write to one target while another target is busy is accepted and does not alter the pending value of the other target. Both commit.
- R6: A write to a target whose busy bit is high is discarded: the pending value still commits. `wr_err` rises and stays high until reset.
- R7: A write with `wr_sel` = 3 changes no register and no busy bit, and does not set `wr_err`.
- R8: When control bit 0 (enable) is set, the count increments by one on each `tclk` edge and wraps from 255 to 0. When it is clear, the count holds.
- R9: When enabled, a `tclk` edge with count equal to compare and no count or compare commit pending sets `match_flag` within five bus clocks.
- R10: A `match_clr` pulse clears `match_flag`. A new hit that arrives in the same cycle takes precedence.
- R11: At a `tclk` edge where a count or compare commit is pending, count equal to compare produces no hit.
- R12: When control bit 1 is set together with enable, the count becomes 0 on the `tclk` edge that registers a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset for both domains |
| wr_en | input | 1 | Write strobe, bus domain |
| wr_sel | input | 2 | Target select: 0 count, 1 compare, 2 control, 3 none |
| wr_data | input | 8 | Write value |
| busy | output | 3 | Per-target commit-pending bits |
| wr_err | output | 1 | Sticky flag for a write dropped while busy |
| match_clr | input | 1 | Clears the match flag |
| match_flag | output | 1 | Sticky compare-hit flag, bus domain |
| tclk | input | 1 | Asynchronous timer clock |
| t_count | output | 8 | Live count, timer domain |
| t_compare | output | 8 | Live compare threshold, timer domain |
| t_control | output | 8 | Live control word, timer domain |

## Verification
The embedded properties check, on every edge, several rules of the handshake and the timer:
- busy rises on each accepted write;
- a holding register stays frozen while its target is busy;
- each request commits only once;
- the counter steps and clears as described;
- the match toggle is blocked while a commit is pending;
- the error flag never drops.

Other behaviour depends on the phase between the two clocks and only the directed scenarios can show it: the exact two-edge commit latency, the round trip that clears busy, the way two targets stay independent, and a hit that is blocked because it falls on the commit edge.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int NREG = 3;
  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } tgt_sel_e;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_CTC_BIT = 1;
endpackage

// File: rtl/tbr_sync_bit.sv
module tbr_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tbr_wr_chan.sv
// One target register: bus-side holding register, busy flag and request toggle.
// The timer side detects the request and returns a toggle acknowledge.
module tbr_wr_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic          busy_q,
  output logic          reject,
  output logic [DW-1:0] hold_q,
  input  logic          tclk,
  output logic          commit
);
  logic req_t;
  logic ack_b;
  logic req_s1;
  logic ack_t;
  logic accept;

  assign accept = wr_stb && !busy_q;
  assign reject = wr_stb && busy_q;

  // bus domain
  always_ff @(posedge clk) begin
    if (rst) begin
      req_t  <= 1'b0;
      hold_q <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      hold_q <= wr_data;
      req_t  <= ~req_t;
      busy_q <= 1'b1;
    end else if (busy_q && (ack_b == req_t)) begin
      busy_q <= 1'b0;
    end
  end

  // timer domain: first edge samples the request; second edge commits and acknowledges
  always_ff @(posedge tclk) begin
    if (rst) begin
      req_s1 <= 1'b0;
      ack_t  <= 1'b0;
    end else begin
      req_s1 <= req_t;
      ack_t  <= req_s1;
    end
  end

  assign commit = (req_s1 != ack_t);

  tbr_sync_bit #(.STAGES(2)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_t),
    .q   (ack_b)
  );

  // R2: an accepted write raises busy and captures the data
  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !busy_q) |=> (busy_q && hold_q == $past(wr_data)));

  // R6: holding register is frozen while busy, so a rejected write leaves it intact
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(hold_q));

  // R3: each request commits on exactly one timer edge
  a_r3_single_commit: assert property (@(posedge tclk) disable iff (rst)
    commit |=> !commit);
endmodule

// File: rtl/tbr_timer_core.sv
module tbr_timer_core
  import tbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          tclk,
  input  logic          rst,
  input  logic          ld_cnt,
  input  logic          ld_cmp,
  input  logic          ld_ctl,
  input  logic [DW-1:0] din_cnt,
  input  logic [DW-1:0] din_cmp,
  input  logic [DW-1:0] din_ctl,
  input  logic          sup,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cmp_q,
  output logic [DW-1:0] ctl_q,
  output logic          match_tog
);
  logic en;
  logic ctc;
  logic hit;

  assign en  = ctl_q[CTL_EN_BIT];
  assign ctc = ctl_q[CTL_CTC_BIT];
  assign hit = en && (cnt_q == cmp_q) && !sup;

  always_ff @(posedge tclk) begin
    if (rst) begin
      cnt_q     <= '0;
      cmp_q     <= '0;
      ctl_q     <= '0;
      match_tog <= 1'b0;
    end else begin
      if (ld_cnt)          cnt_q <= din_cnt;
      else if (hit && ctc) cnt_q <= '0;
      else if (en)         cnt_q <= cnt_q + 1'b1;
      if (ld_cmp) cmp_q <= din_cmp;
      if (ld_ctl) ctl_q <= din_ctl;
      match_tog <= match_tog ^ hit;
    end
  end

  // R11: no hit event while a count or compare commit is pending
  a_r11_no_match_pending: assert property (@(posedge tclk) disable iff (rst)
    sup |=> $stable(match_tog));

  // R12: clear-on-hit returns the count to zero
  a_r12_ctc_clear: assert property (@(posedge tclk) disable iff (rst)
    (hit && ctc && !ld_cnt) |=> (cnt_q == '0));

  // R8: enabled count steps by one when nothing else overrides it
  a_r8_step: assert property (@(posedge tclk) disable iff (rst)
    (en && !ld_cnt && !(hit && ctc)) |=> (cnt_q == DW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/tmr_xdom_wr_bridge.sv
module tmr_xdom_wr_bridge
  import tbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [NREG-1:0] busy,
  output logic            wr_err,
  input  logic            match_clr,
  output logic            match_flag,
  input  logic            tclk,
  output logic [DW-1:0]   t_count,
  output logic [DW-1:0]   t_compare,
  output logic [DW-1:0]   t_control
);
  logic [NREG-1:0]   reject;
  logic [NREG-1:0]   commit;
  logic [DW-1:0]     hold [NREG];
  logic              match_tog;
  logic              mt_b;
  logic              mt_prev;
  logic              hit_evt;

  for (genvar i = 0; i < NREG; i++) begin : g_chan
    tbr_wr_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_en && (wr_sel == 2'(i))),
      .wr_data (wr_data),
      .busy_q  (busy[i]),
      .reject  (reject[i]),
      .hold_q  (hold[i]),
      .tclk    (tclk),
      .commit  (commit[i])
    );
  end

  tbr_timer_core #(.DW(DW)) u_core (
    .tclk      (tclk),
    .rst       (rst),
    .ld_cnt    (commit[SEL_CNT]),
    .ld_cmp    (commit[SEL_CMP]),
    .ld_ctl    (commit[SEL_CTL]),
    .din_cnt   (hold[SEL_CNT]),
    .din_cmp   (hold[SEL_CMP]),
    .din_ctl   (hold[SEL_CTL]),
    .sup       (commit[SEL_CNT] || commit[SEL_CMP]),
    .cnt_q     (t_count),
    .cmp_q     (t_compare),
    .ctl_q     (t_control),
    .match_tog (match_tog)
  );

  tbr_sync_bit #(.STAGES(2)) u_match_sync (
    .clk (clk),
    .rst (rst),
    .d   (match_tog),
    .q   (mt_b)
  );

  assign hit_evt = (mt_b != mt_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      mt_prev    <= 1'b0;
      match_flag <= 1'b0;
      wr_err     <= 1'b0;
    end else begin
      mt_prev <= mt_b;
      if (hit_evt)        match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
      if (|reject) wr_err <= 1'b1;
    end
  end

  // R6: error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  // R10: a clear without a new hit leaves the flag low
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (match_clr && !hit_evt) |=> !match_flag);

  // R7: a write with no valid target touches no busy bit
  a_r7_no_target: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_NONE && busy == '0) |=> (busy == '0));
endmodule

// File: tb/tmr_xdom_wr_bridge_tb.sv
module tmr_xdom_wr_bridge_tb;
  logic       clk = 1'b0;
  logic       tclk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       match_clr = 1'b0;
  logic [2:0] busy;
  logic       wr_err;
  logic       match_flag;
  logic [7:0] t_count;
  logic [7:0] t_compare;
  logic [7:0] t_control;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  always #40 tclk = ~tclk;

  tmr_xdom_wr_bridge #(.DW(8)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .busy       (busy),
    .wr_err     (wr_err),
    .match_clr  (match_clr),
    .match_flag (match_flag),
    .tclk       (tclk),
    .t_count    (t_count),
    .t_compare  (t_compare),
    .t_control  (t_control)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int k = 0; k < 400; k++) begin
      if (busy == 3'b000) return;
      @(negedge clk);
    end
    chk(req, {29'd0, busy}, 32'd0);
  endtask

  task automatic wait_count(input logic [7:0] v, input string req);
    for (int k = 0; k < 600; k++) begin
      @(negedge tclk);
      if (t_count == v) return;
    end
    chk(req, t_count, v);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 wr_err", wr_err, 0);
    chk("R1 match_flag", match_flag, 0);
    chk("R1 count", t_count, 0);
    chk("R1 compare", t_compare, 0);
    chk("R1 control", t_control, 0);
  endtask

  task automatic t_commit_timing;
    int n;
    @(negedge tclk);
    bus_write(2'd0, 8'h5A);
    chk("R2 busy after write", busy, 3'b001);
    @(posedge tclk); #1;
    chk("R3 old value after first edge", t_count, 8'h00);
    @(posedge tclk); #1;
    chk("R3 new value after second edge", t_count, 8'h5A);
    n = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (busy[0] == 1'b0) begin n = k; break; end
    end
    chk("R4 busy clears promptly", (n >= 1 && n <= 4), 1);
  endtask

  task automatic t_two_targets;
    bus_write(2'd1, 8'h33);
    bus_write(2'd0, 8'h44);
    chk("R5 both busy", busy, 3'b011);
    wait_idle("R5 idle");
    @(negedge tclk);
    chk("R5 compare value", t_compare, 8'h33);
    chk("R5 count value", t_count, 8'h44);
    chk("R5 no error", wr_err, 0);
  endtask

  task automatic t_bad_sel;
    bus_write(2'd3, 8'hEE);
    chk("R7 no busy", busy, 0);
    repeat (4) @(negedge tclk);
    chk("R7 no error", wr_err, 0);
    chk("R7 count kept", t_count, 8'h44);
    chk("R7 compare kept", t_compare, 8'h33);
    chk("R7 control kept", t_control, 8'h00);
  endtask

  task automatic t_count_match;
    logic [7:0] a;
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h30);
    wait_idle("R9 setup");
    repeat (3) @(negedge tclk);
    chk("R8 holds when disabled", t_count, 8'h00);
    chk("R9 no hit when disabled", match_flag, 0);
    bus_write(2'd2, 8'h01);
    wait_idle("R8 setup");
    repeat (2) @(negedge tclk);
    a = t_count;
    @(negedge tclk);
    chk("R8 increments", t_count, 8'(a + 1));
    wait_count(8'h31, "R9 reach compare");
    repeat (5) @(negedge clk);
    chk("R9 flag set on hit", match_flag, 1);
    @(negedge clk); match_clr = 1'b1;
    @(negedge clk); match_clr = 1'b0;
    chk("R10 flag cleared", match_flag, 0);
    wait_count(8'hFF, "R8 reach top");
    @(negedge tclk);
    chk("R8 wraps to zero", t_count, 8'h00);
  endtask

  task automatic t_suppress;
    wait_count(8'h2F, "R11 approach");
    chk("R11 flag clear before", match_flag, 0);
    bus_write(2'd0, 8'h10);
    wait_idle("R11 idle");
    repeat (3) @(negedge tclk);
    repeat (5) @(negedge clk);
    chk("R11 no hit during pending commit", match_flag, 0);
    chk("R11 count reloaded", (t_count >= 8'h10 && t_count < 8'h20), 1);
  endtask

  task automatic t_ctc;
    bus_write(2'd2, 8'h00);
    wait_idle("R12 stop");
    bus_write(2'd1, 8'h05);
    bus_write(2'd0, 8'h00);
    wait_idle("R12 setup");
    bus_write(2'd2, 8'h03);
    wait_idle("R12 start");
    wait_count(8'h05, "R12 reach compare");
    @(negedge tclk);
    chk("R12 clears on hit", t_count, 8'h00);
    @(negedge tclk);
    chk("R12 counts again", t_count, 8'h01);
  endtask

  task automatic t_reject;
    bus_write(2'd2, 8'h00);
    wait_idle("R6 stop");
    bus_write(2'd0, 8'h11);
    bus_write(2'd0, 8'h22);
    @(negedge clk);
    chk("R6 error raised", wr_err, 1);
    wait_idle("R6 idle");
    repeat (2) @(negedge tclk);
    chk("R6 first value kept", t_count, 8'h11);
    bus_write(2'd1, 8'h77);
    wait_idle("R6 later");
    chk("R6 error sticky", wr_err, 1);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge tclk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_commit_timing();
    t_two_targets();
    t_bad_sel();
    t_count_match();
    t_suppress();
    t_ctc();
    t_reject();
    finish_run();
  end
endmodule